// File: doc/BRIEF.md
# Spread-Spectrum I/Q Baseband Modulator

This block turns a stream of 4-bit data symbols into two pulse-shaped baseband sample streams for an offset-free quadrature modulator. Each accepted symbol selects a fixed 8-chip pseudo-noise word. The even-numbered chips of that word go to the in-phase branch and the odd-numbered chips go to the quadrature branch, so each symbol yields four chip pairs. Each chip becomes a +1 or -1 impulse at the chip rate. That impulse stream is upsampled by 8 and passed through a half-cosine FIR, and the branch emits one 10-bit signed sample per sample clock.

A single sample-rate clock drives the whole block. The chip rate is one eighth of it and is derived internally as a phase count, so no clock-domain crossing exists and no chip can be dropped or repeated. Symbols arrive over a valid/ready input. Ready is the only back-pressure: it is raised for one cycle at each symbol boundary, and a symbol is taken only in that cycle. The sample outputs run at a fixed cadence and cannot be stalled, so they carry a valid flag and no ready. The `start` pin gates all operation.

Top module: `ssm_iq_modulator`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `i_smp`, `q_smp`, `smp_valid` and the internal state are all zero, and the chip counter is parked at its last count.
- R2: Symbol value s selects the chip word W(s) = rotate-left(8'b1011_1000, s[2:0]), inverted bitwise when s[3] is 1. Chip j of the word is bit j of W(s).
- R3: Chip pair k (k = 0..3, sent in increasing order) puts bit 2k of W(s) on the I branch and bit 2k+1 on the Q branch.
- R4: A chip bit of 1 is sent as a positive pulse and a chip bit of 0 as a negative pulse of the same magnitude.
- R5: Each chip spans 8 output samples. Sample m (m = 0..7) of a chip equals ±round(511·sin(π(m+0.5)/8)), giving 100, 284, 425, 501, 501, 425, 284, 100. Pulses of adjacent chips do not overlap.
- R6: `sym_ready` is high in the first cycle in which `start` is high, and afterwards in one cycle out of every 32 while `start` stays high. It is never high in two consecutive cycles.
- R7: A symbol accepted at clock edge E has its chip pair 0, sample 0 on the outputs just after edge E+2. Its 32 samples follow on consecutive edges.
- R8: If `sym_valid` is low while `sym_ready` is high, the next 32 samples on both branches are zero.
- R9: When `start` is sampled low, both sample outputs and `smp_valid` are zero after that edge, `sym_ready` goes low, and the next rise of `start` begins a fresh symbol period.
- R10: The values on `sym` and `sym_valid` in cycles where `sym_ready` is low have no effect on the outputs.
- R11: `smp_valid` is high after every edge at which `start` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock (8 × chip rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable; low forces idle and zero output |
| sym_valid | input | 1 | Symbol offered |
| sym | input | 4 | Data symbol |
| sym_ready | output | 1 | Symbol taken this cycle if `sym_valid` is high |
| i_smp | output | 10 | In-phase shaped sample, two's complement |
| q_smp | output | 10 | Quadrature shaped sample, two's complement |
| smp_valid | output | 1 | Samples on `i_smp`/`q_smp` are live |

## Verification
All sixteen symbol values are sent back to back. Because each one produces a distinct chip word, this sweep separates errors in the chip table, the I/Q bit selection, the pulse polarity and the tap values, and shows each of these for every chip pair and sample phase. An idle period caused by a missing symbol shows that a skipped handshake outputs silence rather than a repeated word. The symbol input is also changed in every cycle outside the boundary, which exposes any sampling away from the ready cycle. Stopping and restarting `start` and resetting during a run check that the block returns to a clean state and that the first symbol after each event has the correct latency.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // One impulse of the upsampled chip stream: nz marks a chip instant,
  // pos gives its sign (1 = +1, 0 = -1).
  typedef struct packed {
    logic nz;
    logic pos;
  } ssm_imp_t;

  localparam logic [7:0] SSM_SEED_WORD = 8'b1011_1000;

  // Spreading word for a 4-bit symbol: rotate the seed by the low three
  // bits, invert the whole word when the top bit is set.
  function automatic logic [7:0] ssm_chip_word(input logic [3:0] s);
    logic [15:0] dbl;
    logic [7:0]  rot;
    dbl = {SSM_SEED_WORD, SSM_SEED_WORD} << s[2:0];
    rot = dbl[15:8];
    return s[3] ? ~rot : rot;
  endfunction

  // Half-cosine pulse, 8 samples, peak scaled to 511.
  function automatic int ssm_shape_tap(input int m);
    case (m)
      0, 7:    return 100;
      1, 6:    return 284;
      2, 5:    return 425;
      3, 4:    return 501;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ssm_sequencer.sv
module ssm_sequencer
  import ssm_pkg::*;
#(
  parameter int OSR   = 8,
  parameter int PAIRS = 4,
  parameter int SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             sym_ready,
  output ssm_imp_t         imp_i,
  output ssm_imp_t         imp_q
);

  localparam int PERIOD = OSR * PAIRS;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int PH_W   = $clog2(OSR);
  localparam int PR_W   = (CNT_W - PH_W) > 0 ? (CNT_W - PH_W) : 1;
  localparam int CHIPS  = 2 * PAIRS;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic [CHIPS-1:0] word;
  logic             live;

  logic [PH_W-1:0]  ph;
  logic [PR_W-1:0]  pair;

  assign sym_ready = start && (cnt == LAST);
  assign ph        = cnt[PH_W-1:0];
  assign pair      = PR_W'(cnt >> PH_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= LAST;
      word <= '0;
      live <= 1'b0;
    end else if (!start) begin
      cnt  <= LAST;
      word <= '0;
      live <= 1'b0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (sym_ready) begin
        live <= sym_valid;
        word <= sym_valid ? CHIPS'(ssm_chip_word(4'(sym))) : '0;
      end
    end
  end

  // Chip instants occur at phase 0 of each pair slot.
  always_comb begin
    imp_i.nz  = start && live && (ph == '0);
    imp_q.nz  = start && live && (ph == '0);
    imp_i.pos = word[2*pair];
    imp_q.pos = word[2*pair+1];
  end

  // R6: ready is a single-cycle strobe
  a_r6_ready_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready |=> !sym_ready);

  // R7: acceptance restarts the symbol period at count zero
  a_r7_accept_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (cnt == '0 && live));

  // R8: a missed handshake yields a silent period
  a_r8_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && sym_ready) |=> (!imp_i.nz && !imp_q.nz));

endmodule

// File: rtl/ssm_shaper.sv
module ssm_shaper
  import ssm_pkg::*;
#(
  parameter int OSR   = 8,
  parameter int OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  ssm_imp_t                imp,
  output logic signed [OUT_W-1:0] y
);

  localparam int ACC_W = OUT_W + $clog2(OSR) + 1;

  ssm_imp_t                 line [OSR];
  logic signed [ACC_W-1:0]  term [OSR];
  logic signed [ACC_W-1:0]  acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < OSR; j++) line[j] <= '0;
    end else if (clr) begin
      for (int j = 0; j < OSR; j++) line[j] <= '0;
    end else begin
      line[0] <= imp;
      for (int j = 1; j < OSR; j++) line[j] <= line[j-1];
    end
  end

  for (genvar g = 0; g < OSR; g++) begin : g_tap
    localparam logic signed [ACC_W-1:0] COEF = ACC_W'(ssm_shape_tap(g));
    always_comb begin
      if (!line[g].nz)      term[g] = '0;
      else if (line[g].pos) term[g] = COEF;
      else                  term[g] = -COEF;
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < OSR; j++) acc = acc + term[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   y <= '0;
    else if (clr) y <= '0;
    else          y <= acc[OUT_W-1:0];
  end

  // R9: a clear leaves silence on the output
  a_r9_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (y == '0));

  // R5: shaped output never reaches the most negative code
  a_r5_peak_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    y != {1'b1, {(OUT_W-1){1'b0}}});

endmodule

// File: rtl/ssm_iq_modulator.sv
module ssm_iq_modulator
  import ssm_pkg::*;
#(
  parameter int OSR   = 8,
  parameter int PAIRS = 4,
  parameter int SYM_W = 4,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             sym_ready,
  output logic [OUT_W-1:0] i_smp,
  output logic [OUT_W-1:0] q_smp,
  output logic             smp_valid
);

  localparam int BRANCHES = 2;

  ssm_imp_t                 imp [BRANCHES];
  logic signed [OUT_W-1:0]  smp [BRANCHES];

  ssm_sequencer #(
    .OSR   (OSR),
    .PAIRS (PAIRS),
    .SYM_W (SYM_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sym_valid (sym_valid),
    .sym       (sym),
    .sym_ready (sym_ready),
    .imp_i     (imp[0]),
    .imp_q     (imp[1])
  );

  for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
    ssm_shaper #(
      .OSR   (OSR),
      .OUT_W (OUT_W)
    ) u_shape (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!start),
      .imp   (imp[b]),
      .y     (smp[b])
    );
  end

  assign i_smp = smp[0];
  assign q_smp = smp[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_valid <= 1'b0;
    else        smp_valid <= start;
  end

  // R11: valid tracks the sampled run enable
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> smp_valid);

  // R9: stopping silences both branches and drops ready
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (i_smp == '0 && q_smp == '0 && !smp_valid));

endmodule

// File: tb/tb_ssm_iq_modulator.sv
module tb_ssm_iq_modulator;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sym_valid = 1'b0;
  logic [3:0] sym = 4'd0;
  logic       sym_ready;
  logic [9:0] i_smp;
  logic [9:0] q_smp;
  logic       smp_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int  sch_sym [24];
  bit  sch_v   [24];

  always #2 clk = ~clk;

  ssm_iq_modulator dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sym_valid (sym_valid),
    .sym       (sym),
    .sym_ready (sym_ready),
    .i_smp     (i_smp),
    .q_smp     (q_smp),
    .smp_valid (smp_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_word(input int s);
    logic [7:0] w;
    int r;
    r = s % 8;
    w = 8'hB8;
    for (int i = 0; i < r; i++) w = {w[6:0], w[7]};
    if (s >= 8) w = ~w;
    return w;
  endfunction

  function automatic int ref_tap(input int m);
    real x;
    x = 511.0 * $sin(3.14159265358979 * (m + 0.5) / 8.0);
    return $rtoi(x + 0.5);
  endfunction

  // Expected sample for output index u = edges since start minus 2.
  function automatic int ref_smp(input int u, input int br);
    int s, k, m;
    logic [7:0] w;
    if (u < 0) return 0;
    s = u / 32;
    if (!sch_v[s]) return 0;
    k = (u % 32) / 8;
    m = u % 8;
    w = ref_word(sch_sym[s]);
    return w[2*k+br] ? ref_tap(m) : -ref_tap(m);
  endfunction

  // Runs nper symbol periods from a rising start; caller is at a negedge
  // with start low.
  task automatic run_sched(input int nper);
    int t_end;
    t_end = nper * 32 + 2;
    start = 1'b1;
    sym = 4'(sch_sym[0]);
    sym_valid = sch_v[0];
    #0;
    chk(sym_ready == 1'b1, "R6 ready on start rise", int'(sym_ready), 1);
    for (int t = 0; t < t_end; t++) begin
      int ei, eq;
      @(posedge clk);
      @(negedge clk);
      ei = ref_smp(t - 2, 0);
      eq = ref_smp(t - 2, 1);
      chk($signed(i_smp) == ei, "R2 R3 R4 R5 R7 R8 R10 i_smp",
          int'($signed(i_smp)), ei);
      chk($signed(q_smp) == eq, "R2 R3 R4 R5 R7 R8 R10 q_smp",
          int'($signed(q_smp)), eq);
      chk(smp_valid == 1'b1, "R11 smp_valid", int'(smp_valid), 1);
      if ((t + 1) % 32 == 0) begin
        sym = 4'(sch_sym[(t + 1) / 32]);
        sym_valid = sch_v[(t + 1) / 32];
        #0;
        chk(sym_ready == 1'b1, "R6 ready at boundary", int'(sym_ready), 1);
      end else begin
        // R10: scramble the symbol input away from the boundary
        sym = 4'((t * 7 + 5) % 16);
        sym_valid = t[0];
        #0;
        chk(sym_ready == 1'b0, "R6 ready low mid-period", int'(sym_ready), 0);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(i_smp == '0, "R1 i_smp in reset", int'(i_smp), 0);
    chk(q_smp == '0, "R1 q_smp in reset", int'(q_smp), 0);
    chk(smp_valid == 1'b0, "R1 smp_valid in reset", int'(smp_valid), 0);
    chk(sym_ready == 1'b0, "R1 ready in reset", int'(sym_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(i_smp == '0 && q_smp == '0, "R1 idle after reset", int'(i_smp), 0);

    // Exhaustive sweep of all symbols, then a missed handshake, then one more.
    for (int s = 0; s < 16; s++) begin
      sch_sym[s] = s;
      sch_v[s] = 1'b1;
    end
    sch_sym[16] = 6;  sch_v[16] = 1'b0;   // R8 idle period
    sch_sym[17] = 9;  sch_v[17] = 1'b1;
    sch_sym[18] = 0;  sch_v[18] = 1'b0;
    run_sched(18);

    // R9: stop
    start = 1'b0;
    sym_valid = 1'b1;
    #0;
    chk(sym_ready == 1'b0, "R9 ready drops with start", int'(sym_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(i_smp == '0, "R9 i_smp zero when stopped", int'(i_smp), 0);
    chk(q_smp == '0, "R9 q_smp zero when stopped", int'(q_smp), 0);
    chk(smp_valid == 1'b0, "R11 smp_valid low when stopped", int'(smp_valid), 0);
    repeat (5) @(negedge clk);
    chk(i_smp == '0 && q_smp == '0, "R9 stays silent", int'(i_smp), 0);

    // Restart: fresh period with new symbols
    sch_sym[0] = 3;  sch_v[0] = 1'b1;
    sch_sym[1] = 12; sch_v[1] = 1'b1;
    sch_sym[2] = 0;  sch_v[2] = 1'b0;
    run_sched(2);

    // Stop mid-symbol, restart at once
    sch_sym[0] = 15; sch_v[0] = 1'b1;
    sch_sym[1] = 0;  sch_v[1] = 1'b0;
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    run_sched(1);

    // R1: asynchronous reset in the middle of a run
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(i_smp == '0, "R1 async reset clears i_smp", int'(i_smp), 0);
    chk(q_smp == '0, "R1 async reset clears q_smp", int'(q_smp), 0);
    chk(smp_valid == 1'b0, "R1 async reset clears valid", int'(smp_valid), 0);
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    sch_sym[0] = 10; sch_v[0] = 1'b1;
    sch_sym[1] = 0;  sch_v[1] = 1'b0;
    run_sched(1);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule